// File: doc/BRIEF.md
# Three-Tier Sound Level History Buffer

This block keeps a rolling record of 8-bit A-weighted sound level values at three time scales: sixty per-second values, sixty per-minute values and twelve per-hour values. Each tier is a shift register. A strobe with a value pushes that value in as the newest entry. Every older entry moves one place further from the tier's base address, and the oldest entry falls off the far end. The caller computes the per-minute and per-hour values and supplies them with their strobes.

All three tiers are placed in one byte-wide address space and share a single read port. The read data is registered, so it appears one clock after the address. A value of 0 in any entry means that no valid data has arrived there yet. A clear pulse empties every tier at once.

A small fill tracker counts per-second inserts and raises a one-cycle full flag on every sixtieth insert after reset or clear. The tracker has three states:
- FILL_EMPTY: nothing inserted since reset or clear.
- FILL_COUNT: counting toward the next sixty.
- FILL_FULL: the one cycle in which the flag is high.

Its transitions are:
- first insert: FILL_EMPTY to FILL_COUNT.
- count step: FILL_COUNT to FILL_COUNT, the count advancing.
- wrap: FILL_COUNT to FILL_FULL, on the sixtieth insert.
- resume: FILL_FULL to FILL_COUNT, with the count at 1 if an insert arrives in that cycle and at 0 otherwise.
- clear: any state to FILL_EMPTY.

Top module: `lvl_hist_buf`

## Requirements
- R1: After reset every entry reads 0 and `sec_full` is 0.
- R2: The seconds tier is read at addresses 100 to 159. Each `sec_stb` stores `sec_val` at 100 and moves the entry at address a to a+1, so 159 holds the oldest value and the value that was at 159 is discarded.
- R3: The minutes tier is read at addresses 160 to 219. It shifts only on `min_stb`, with the newest value at 160.
- R4: The hours tier is read at addresses 220 to 231 and holds 12 entries. It shifts only on `hr_stb`, with the newest value at 220.
- R5: A `hist_clr` pulse sets every entry of all three tiers to 0 and restarts the count of seconds inserts from zero.
- R6: `sec_full` is high for exactly one cycle, in the cycle after the clock edge that stores the 60th seconds insert counted since reset or clear. After that, counting restarts at zero.
- R7: A read of any address below 100 or above 231 returns 0.
- R8: When strobes for several tiers arrive in the same cycle, each strobed tier shifts exactly once and no other tier moves.
- R9: A `hist_clr` in the same cycle as any strobe wins. All tiers are left at 0, and that seconds insert is not counted toward R6.
- R10: `rd_data` shows the entry at the `rd_addr` sampled at the previous clock edge. A value inserted at one edge can be read from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hist_clr | input | 1 | Clear all tiers (one-cycle pulse) |
| sec_stb | input | 1 | Per-second insert strobe |
| sec_val | input | 8 | Value inserted into the seconds tier |
| min_stb | input | 1 | Per-minute insert strobe |
| min_val | input | 8 | Value inserted into the minutes tier |
| hr_stb | input | 1 | Per-hour insert strobe |
| hr_val | input | 8 | Value inserted into the hours tier |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| sec_full | output | 1 | One-cycle pulse on every 60th seconds insert |

## Verification
Port-level checks can catch the following internal faults:
- A wrong shift, such as a skipped or doubled move or a tier moving on another tier's strobe, shows as a shifted or duplicated byte. It appears at the affected address on the first read after the insert, one clock after that address is presented.
- A stale or miscounted fill state has no effect on the data. It shows only on `sec_full`, possibly many inserts later, when the pulse comes one insert early or late.
- A clear that loses to a same-cycle insert leaves a non-zero byte at address 100, 160 or 220.

For these reasons the bench sweeps the whole address space after each phase and checks `sec_full` after every insert.

// File: rtl/lvl_hist_pkg.sv
package lvl_hist_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_COUNT = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/hist_tier.sv
module hist_tier #(
    parameter int DEPTH  = 60,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [DATA_W-1:0]             din,
    output logic [DEPTH-1:0][DATA_W-1:0]  slots
);
    // slot 0 is the newest entry, slot DEPTH-1 the oldest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
        end else if (clr) begin
            slots <= '0;
        end else if (push) begin
            slots <= {slots[DEPTH-2:0], din};
        end
    end

    // R2/R3/R4: a push lands at the base slot
    a_r2_newest_at_base: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> (slots[0] == $past(din)));
    // R5/R9: clear leaves the tier empty regardless of push
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (slots == '0));
    // R8: no strobe, no movement
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> $stable(slots));
endmodule

// File: rtl/sec_fill_fsm.sv
module sec_fill_fsm
    import lvl_hist_pkg::*;
#(
    parameter int DEPTH = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    output logic full
);
    localparam int CNT_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    fill_state_e      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= FILL_EMPTY;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (clr) begin
            st_n  = FILL_EMPTY;
            cnt_n = '0;
        end else begin
            unique case (st)
                FILL_EMPTY: begin
                    if (push) begin
                        st_n  = FILL_COUNT;
                        cnt_n = CNT_W'(1);
                    end
                end
                FILL_COUNT: begin
                    if (push) begin
                        if (cnt == LAST) begin
                            st_n  = FILL_FULL;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
                FILL_FULL: begin
                    st_n  = FILL_COUNT;
                    cnt_n = push ? CNT_W'(1) : '0;
                end
                default: begin
                    st_n  = FILL_EMPTY;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        full = (st == FILL_FULL);
    end

    // R6: the flag is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !full);
    // R6: the flag only follows a counted insert
    a_r6_after_insert: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> ($past(push) && !$past(clr)));
    // R9: a clear never produces the flag
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!full && st == FILL_EMPTY));
    // R6: count stays inside one fill window
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/hist_rd_port.sv
module hist_rd_port #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int SEC_BASE  = 100,
    parameter int SEC_DEPTH = 60,
    parameter int MIN_DEPTH = 60,
    parameter int HR_DEPTH  = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic [SEC_DEPTH-1:0][DATA_W-1:0]  sec_slots,
    input  logic [MIN_DEPTH-1:0][DATA_W-1:0]  min_slots,
    input  logic [HR_DEPTH-1:0][DATA_W-1:0]   hr_slots,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int MIN_BASE = SEC_BASE + SEC_DEPTH;
    localparam int HR_BASE  = MIN_BASE + MIN_DEPTH;
    localparam int HR_END   = HR_BASE + HR_DEPTH;
    localparam int SEC_IW   = $clog2(SEC_DEPTH);
    localparam int MIN_IW   = $clog2(MIN_DEPTH);
    localparam int HR_IW    = $clog2(HR_DEPTH);

    logic              in_sec, in_min, in_hr, in_any;
    logic [SEC_IW-1:0] sec_idx;
    logic [MIN_IW-1:0] min_idx;
    logic [HR_IW-1:0]  hr_idx;
    logic [DATA_W-1:0] sel;

    always_comb begin
        in_sec  = (rd_addr >= ADDR_W'(SEC_BASE)) && (rd_addr < ADDR_W'(MIN_BASE));
        in_min  = (rd_addr >= ADDR_W'(MIN_BASE)) && (rd_addr < ADDR_W'(HR_BASE));
        in_hr   = (rd_addr >= ADDR_W'(HR_BASE))  && (rd_addr < ADDR_W'(HR_END));
        in_any  = in_sec || in_min || in_hr;
        sec_idx = SEC_IW'(rd_addr - ADDR_W'(SEC_BASE));
        min_idx = MIN_IW'(rd_addr - ADDR_W'(MIN_BASE));
        hr_idx  = HR_IW'(rd_addr - ADDR_W'(HR_BASE));
        sel     = '0;
        if (in_sec)      sel = sec_slots[sec_idx];
        else if (in_min) sel = min_slots[min_idx];
        else if (in_hr)  sel = hr_slots[hr_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= sel;
    end

    // R7: unmapped addresses read as zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_any |=> (rd_data == '0));
    // R10: the regions never overlap
    a_r10_one_region: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({in_sec, in_min, in_hr}) <= 1);
endmodule

// File: rtl/lvl_hist_buf.sv
module lvl_hist_buf #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int SEC_BASE  = 100,
    parameter int SEC_DEPTH = 60,
    parameter int MIN_DEPTH = 60,
    parameter int HR_DEPTH  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hist_clr,
    input  logic              sec_stb,
    input  logic [DATA_W-1:0] sec_val,
    input  logic              min_stb,
    input  logic [DATA_W-1:0] min_val,
    input  logic              hr_stb,
    input  logic [DATA_W-1:0] hr_val,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sec_full
);
    logic [SEC_DEPTH-1:0][DATA_W-1:0] sec_slots;
    logic [MIN_DEPTH-1:0][DATA_W-1:0] min_slots;
    logic [HR_DEPTH-1:0][DATA_W-1:0]  hr_slots;

    hist_tier #(.DEPTH(SEC_DEPTH), .DATA_W(DATA_W)) u_sec_tier (
        .clk(clk), .rst_n(rst_n), .clr(hist_clr), .push(sec_stb),
        .din(sec_val), .slots(sec_slots));

    hist_tier #(.DEPTH(MIN_DEPTH), .DATA_W(DATA_W)) u_min_tier (
        .clk(clk), .rst_n(rst_n), .clr(hist_clr), .push(min_stb),
        .din(min_val), .slots(min_slots));

    hist_tier #(.DEPTH(HR_DEPTH), .DATA_W(DATA_W)) u_hr_tier (
        .clk(clk), .rst_n(rst_n), .clr(hist_clr), .push(hr_stb),
        .din(hr_val), .slots(hr_slots));

    sec_fill_fsm #(.DEPTH(SEC_DEPTH)) u_fill (
        .clk(clk), .rst_n(rst_n), .clr(hist_clr), .push(sec_stb),
        .full(sec_full));

    hist_rd_port #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_BASE(SEC_BASE),
        .SEC_DEPTH(SEC_DEPTH), .MIN_DEPTH(MIN_DEPTH), .HR_DEPTH(HR_DEPTH)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
        .sec_slots(sec_slots), .min_slots(min_slots), .hr_slots(hr_slots),
        .rd_data(rd_data));

    // R1: the port is quiet while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !sec_full));
endmodule

// File: tb/lvl_hist_buf_tb_top.sv
module lvl_hist_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hist_clr = 1'b0;
    logic       sec_stb = 1'b0, min_stb = 1'b0, hr_stb = 1'b0;
    logic [7:0] sec_val = '0, min_val = '0, hr_val = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sec_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_sec [60];
    int m_min [60];
    int m_hr  [12];
    int m_cnt = 0;

    int    qa [$];
    int    qe [$];
    string qt [$];

    always #4 clk = ~clk;

    lvl_hist_buf dut_i (
        .clk(clk), .rst_n(rst_n), .hist_clr(hist_clr),
        .sec_stb(sec_stb), .sec_val(sec_val),
        .min_stb(min_stb), .min_val(min_val),
        .hr_stb(hr_stb), .hr_val(hr_val),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_full(sec_full));

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_at(int a);
        if (a >= 100 && a < 160) return m_sec[a-100];
        if (a >= 160 && a < 220) return m_min[a-160];
        if (a >= 220 && a < 232) return m_hr[a-220];
        return 0;
    endfunction

    function automatic string tag_for(int a);
        if (a >= 100 && a < 160) return "R2";
        if (a >= 160 && a < 220) return "R3";
        if (a >= 220 && a < 232) return "R4";
        return "R7";
    endfunction

    // driver: present an address, queue the expected byte
    task automatic rd(int a, string tag);
        @(negedge clk);
        rd_addr = 8'(a);
        qa.push_back(a);
        qe.push_back(exp_at(a));
        qt.push_back(tag == "" ? tag_for(a) : tag);
    endtask

    task automatic sweep(string tag);
        for (int a = 100; a < 232; a++) rd(a, tag);
    endtask

    // driver: one insert/clear cycle, model update, full-flag check
    task automatic ins(bit s, bit m, bit h, bit c, int sv, int mv, int hv, string tag);
        bit exp_full;
        exp_full = 1'b0;
        @(negedge clk);
        sec_stb = s; min_stb = m; hr_stb = h; hist_clr = c;
        sec_val = 8'(sv); min_val = 8'(mv); hr_val = 8'(hv);
        if (c) begin
            foreach (m_sec[i]) m_sec[i] = 0;
            foreach (m_min[i]) m_min[i] = 0;
            foreach (m_hr[i])  m_hr[i]  = 0;
            m_cnt = 0;
        end else begin
            if (s) begin
                for (int i = 59; i > 0; i--) m_sec[i] = m_sec[i-1];
                m_sec[0] = sv & 255;
                m_cnt++;
                if (m_cnt == 60) begin exp_full = 1'b1; m_cnt = 0; end
            end
            if (m) begin
                for (int i = 59; i > 0; i--) m_min[i] = m_min[i-1];
                m_min[0] = mv & 255;
            end
            if (h) begin
                for (int i = 11; i > 0; i--) m_hr[i] = m_hr[i-1];
                m_hr[0] = hv & 255;
            end
        end
        @(negedge clk);
        check(sec_full == exp_full, {tag, " sec_full"}, int'(sec_full), int'(exp_full));
        sec_stb = 0; min_stb = 0; hr_stb = 0; hist_clr = 0;
    endtask

    // monitor: compare registered read data one edge after the address
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (qa.size() > 0) begin
                int a, e;
                string t;
                a = qa.pop_front();
                e = qe.pop_front();
                t = qt.pop_front();
                check(int'(rd_data) == e, $sformatf("%s addr=%0d", t, a), int'(rd_data), e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        foreach (m_sec[i]) m_sec[i] = 0;
        foreach (m_min[i]) m_min[i] = 0;
        foreach (m_hr[i])  m_hr[i]  = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(sec_full == 1'b0, "R1 sec_full", int'(sec_full), 0);
        rd(100, "R1"); rd(159, "R1"); rd(160, "R1");
        rd(219, "R1"); rd(220, "R1"); rd(231, "R1");

        // R2/R10: first seconds inserts, read right after
        for (int i = 1; i <= 5; i++) ins(1, 0, 0, 0, i * 3, 0, 0, "R6");
        rd(100, "R10"); rd(104, "R10"); rd(105, "R10");
        sweep("");

        // R7: unmapped reads with data present
        rd(0, "R7"); rd(99, "R7"); rd(232, "R7"); rd(255, "R7");

        // R8: all three strobes together
        ins(1, 1, 1, 0, 200, 77, 99, "R8");
        rd(100, "R8"); rd(101, "R8"); rd(160, "R8");
        rd(161, "R8"); rd(220, "R8"); rd(221, "R8");

        // R6: complete 60 seconds inserts, then wrap past the oldest
        for (int i = 0; i < 54; i++) ins(1, 0, 0, 0, 20 + i, 0, 0, "R6");
        for (int i = 0; i < 10; i++) ins(1, 0, 0, 0, 150 + i, 0, 0, "R2");
        sweep("");

        // R3/R4: fill and overflow minutes and hours
        for (int i = 0; i < 62; i++) ins(0, 1, 0, 0, 0, (i % 250) + 1, 0, "R3");
        for (int i = 0; i < 14; i++) ins(0, 0, 1, 0, 0, 0, 100 + i, "R4");
        sweep("");

        // R5: clear empties all and restarts counting
        ins(0, 0, 0, 1, 0, 0, 0, "R5");
        sweep("R5");
        for (int i = 0; i < 60; i++) ins(1, 0, 0, 0, i + 1, 0, 0, "R5");
        rd(100, "R5"); rd(159, "R5");

        // R9: clear together with inserts
        for (int i = 0; i < 7; i++) ins(1, 1, 1, 0, 40 + i, 60 + i, 80 + i, "R9");
        ins(1, 1, 1, 1, 33, 44, 55, "R9");
        sweep("R9");
        for (int i = 0; i < 60; i++) ins(1, 0, 0, 0, 90 + i, 0, 0, "R9");
        rd(100, "R9"); rd(159, "R9"); rd(160, "R9"); rd(220, "R9");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule